// File: doc/BRIEF.md
# Segment Table Address Widener

This block turns a 32-bit effective address into a 52-bit virtual address. The top four bits of the effective address pick one of sixteen segment registers. The 24-bit segment identifier held in that register is placed above the low 28 bits of the effective address, and the result is the widened address. The lookup path has no registers, so the widened address follows the effective address within the same cycle.

Software changes table entries through a write port. A write goes through only when the requester is privileged. A write from unprivileged code leaves the table as it was and raises a fault pulse for one cycle. A separate read port returns any entry, and it answers at every privilege level.

Top module: `seg_xlate`

## Requirements
- R1: `va_o` equals `{seg[ea_i[31:28]], ea_i[27:0]}` combinationally, where `seg[k]` is the 24-bit identifier stored in entry k.
- R2: After reset is asserted, every entry holds zero, `va_o[51:28]` is zero for any `ea_i`, and `priv_fault_o` is low.
- R3: A write with `wr_en_i=1` and `wr_priv_i=1` stores `wr_data_i` into entry `wr_idx_i` at the next rising clock edge. No other entry changes.
- R4: A write with `wr_en_i=1` and `wr_priv_i=0` changes no entry.
- R5: `priv_fault_o` is high for exactly the one cycle that follows the edge that sampled a refused write, and it is low at all other times.
- R6: A lookup or read in the same cycle as a write to the same entry returns the old value. The new value is visible after the edge.
- R7: `rd_data_o` equals `seg[rd_idx_i]` combinationally, at any privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_i | input | 32 | Effective address |
| va_o | output | 52 | Widened virtual address |
| wr_en_i | input | 1 | Table write request |
| wr_priv_i | input | 1 | Requester is privileged |
| wr_idx_i | input | 4 | Entry to write |
| wr_data_i | input | 24 | Segment identifier to store |
| priv_fault_o | output | 1 | One-cycle pulse for a refused write |
| rd_idx_i | input | 4 | Entry to read |
| rd_data_o | output | 24 | Content of the selected entry |

## Verification
`va_o` and `rd_data_o` are combinational, so the bench checks them in the same cycle it drives the indices, sampling on the falling edge. A table write changes state at the rising edge that follows the write cycle, so a check of the new value is made at the next falling edge. The fault pulse appears one edge after the refused request and is sampled in that cycle and in the cycle after it. The bench loads every entry with a distinct value and then sweeps all 16 top nibbles against a model of the table kept in the bench.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int unsigned EA_W   = 32;
  parameter int unsigned SEL_W  = 4;
  parameter int unsigned SEG_W  = 24;
  localparam int unsigned OFF_W = EA_W - SEL_W;
  localparam int unsigned VA_W  = SEG_W + OFF_W;
  localparam int unsigned N_SEG = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic             priv;
    logic [SEL_W-1:0] idx;
    logic [SEG_W-1:0] data;
  } seg_wr_t;
endpackage

// File: rtl/seg_wr_gate.sv
module seg_wr_gate
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seg_wr_t          req_i,
  output logic [N_SEG-1:0] ld_o,
  output logic             fault_o
);
  logic fault_d, fault_q;

  always_comb begin
    ld_o = '0;
    if (req_i.en && req_i.priv) ld_o[req_i.idx] = 1'b1;
    fault_d = req_i.en && !req_i.priv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault_o = fault_q;

  assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.en && !req_i.priv) |=> fault_o);
  assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i.en && !req_i.priv) |=> !fault_o);
  assert_no_load_unpriv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i.priv |-> (ld_o == '0));
  always_comb assert_ld_onehot_R3: assert ($onehot0(ld_o));
endmodule

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SEG-1:0] ld_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] sel_a_i,
  output logic [SEG_W-1:0] seg_a_o,
  input  logic [SEL_W-1:0] sel_b_i,
  output logic [SEG_W-1:0] seg_b_o
);
  logic [SEG_W-1:0] seg_q [N_SEG];

  for (genvar k = 0; k < N_SEG; k++) begin : g_ent
    logic [SEG_W-1:0] seg_d;
    always_comb seg_d = ld_i[k] ? wdata_i : seg_q[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[k] <= '0;
      else        seg_q[k] <= seg_d;
    end
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i[k] |=> $stable(seg_q[k]));
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i[k] |=> (seg_q[k] == $past(wdata_i)));
  end

  assign seg_a_o = seg_q[sel_a_i];
  assign seg_b_o = seg_q[sel_b_i];
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ea_i,
  output logic [51:0] va_o,
  input  logic        wr_en_i,
  input  logic        wr_priv_i,
  input  logic [3:0]  wr_idx_i,
  input  logic [23:0] wr_data_i,
  output logic        priv_fault_o,
  input  logic [3:0]  rd_idx_i,
  output logic [23:0] rd_data_o
);
  seg_wr_t          wreq;
  logic [N_SEG-1:0] ld;
  logic [SEG_W-1:0] seg_sel;

  always_comb begin
    wreq.en   = wr_en_i;
    wreq.priv = wr_priv_i;
    wreq.idx  = wr_idx_i;
    wreq.data = wr_data_i;
  end

  seg_wr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req_i(wreq), .ld_o(ld), .fault_o(priv_fault_o)
  );

  seg_table u_tab (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .wdata_i(wreq.data),
    .sel_a_i(ea_i[EA_W-1 -: SEL_W]), .seg_a_o(seg_sel),
    .sel_b_i(rd_idx_i), .seg_b_o(rd_data_o)
  );

  assign va_o = {seg_sel, ea_i[OFF_W-1:0]};

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    va_o[OFF_W-1:0] == ea_i[OFF_W-1:0]);
  assert_ports_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i == ea_i[31:28]) |-> (rd_data_o == va_o[51:28]));
  assert_unpriv_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_priv_i && rd_idx_i == wr_idx_i) |=>
      ($past(rd_idx_i) != rd_idx_i) || $stable(rd_data_o));
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ea;
  logic [51:0] va;
  logic        wen, wpriv;
  logic [3:0]  widx, ridx;
  logic [23:0] wdata, rdata;
  logic        fault;
  logic [23:0] model [16];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .ea_i(ea), .va_o(va), .wr_en_i(wen),
    .wr_priv_i(wpriv), .wr_idx_i(widx), .wr_data_i(wdata),
    .priv_fault_o(fault), .rd_idx_i(ridx), .rd_data_o(rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sweep(input string req, input logic [27:0] off);
    for (int k = 0; k < 16; k++) begin
      ea = {k[3:0], off}; ridx = k[3:0];
      #1;
      chk(req, {12'h0, va}, {12'h0, model[k], off});
      chk("R7", {40'h0, rdata}, {40'h0, model[k]});
    end
  endtask

  task automatic wr(input logic p, input logic [3:0] i, input logic [23:0] d);
    @(negedge clk);
    wen = 1'b1; wpriv = p; widx = i; wdata = d;
    @(negedge clk);
    wen = 1'b0;
    if (p) model[i] = d;
  endtask

  initial begin
    #150000;
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ea = '0; wen = 1'b0; wpriv = 1'b0; widx = '0; wdata = '0; ridx = '0;
    for (int k = 0; k < 16; k++) model[k] = '0;
    #45;
    chk("R2", {63'h0, fault}, 64'h0);
    sweep("R2", 28'hABCDEF1);
    @(negedge clk); rst_n = 1'b1;
    // R3: load distinct values with privilege
    for (int k = 0; k < 16; k++) wr(1'b1, k[3:0], 24'h5A0000 ^ (k * 24'h010203));
    sweep("R1", 28'h0000000);
    sweep("R1", 28'hFFFFFFF);
    sweep("R3", 28'h1234567);
    // R4/R5: refused write
    @(negedge clk);
    wen = 1'b1; wpriv = 1'b0; widx = 4'd7; wdata = 24'hDEAD01;
    chk("R5", {63'h0, fault}, 64'h0);
    @(negedge clk);
    wen = 1'b0;
    chk("R5", {63'h0, fault}, 64'h1);
    @(negedge clk);
    chk("R5", {63'h0, fault}, 64'h0);
    ridx = 4'd7; #1;
    chk("R4", {40'h0, rdata}, {40'h0, model[7]});
    sweep("R4", 28'h0F0F0F0);
    // R6: same-cycle lookup returns old value
    @(negedge clk);
    wen = 1'b1; wpriv = 1'b1; widx = 4'd3; wdata = 24'hC0FFEE;
    ea = {4'd3, 28'h0000ABC}; ridx = 4'd3; #1;
    chk("R6", {12'h0, va}, {12'h0, model[3], 28'h0000ABC});
    chk("R6", {40'h0, rdata}, {40'h0, model[3]});
    @(negedge clk);
    wen = 1'b0; model[3] = 24'hC0FFEE; #1;
    chk("R6", {12'h0, va}, {12'h0, 24'hC0FFEE, 28'h0000ABC});
    chk("R5", {63'h0, fault}, 64'h0);
    sweep("R3", 28'h8000001);
    // R2: reset again
    @(negedge clk); rst_n = 1'b0;
    for (int k = 0; k < 16; k++) model[k] = '0;
    #1;
    sweep("R2", 28'h7654321);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule